// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write path between a host bus and a flash array controller. Host writes that reach a selected flash or boot sector are not stored in memory. The decoder reads each one as one step of a multi-cycle command. Each command opens with a fixed pair of unlock writes, then an opcode, and some commands need further writes. When the last expected write of a valid command arrives, the decoder sends the array controller a one-cycle command strobe. The strobe carries a command code together with the address and data word of that final write. The array controller does the programming and erasing itself.

The decoder runs in two bus modes. In byte mode the unlock steps use low addresses 555h and AAAh. In word mode they use AAAh and 554h, every command write must use an even address, and only the low data byte is compared. Address bits 12 and above are never compared. The decoder drops a partly received command and falls back to plain array reads in two cases: when a write does not fit the expected sequence, and when too many idle cycles pass between two writes. The decoder also tracks identifier mode and unlock bypass mode. It produces the status byte that the host reads while an embedded operation is running.

Top module: `flash_cmd_decoder`

## Requirements
- R1: In byte mode (`wide_mode`=0), the writes AAh@555h, 55h@AAAh, op give a `cmd_valid` pulse in the cycle after the op write is sampled. The op values are F0h→RESET (code 1), 90h→IDENT (2), 20h→BYPASS (8), B0h→SUSPEND (6) and 30h→RESUME (7). `cmd_addr` and `cmd_data` hold the final write's full address and full 16-bit data.
- R2: In word mode (`wide_mode`=1), the unlock writes are AAh@AAAh and then 55h@554h. Only data bits 7:0 are compared, so bits 15:8 are ignored.
- R3: In word mode, a selected write to an odd address aborts the sequence and gives no strobe. In byte mode, odd addresses are accepted.
- R4: Only address bits 11:0 are compared. A write with no bit set in `sect_sel` or `boot_sel` is ignored: it does not change the sequence state and does not restart the timer.
- R5: A selected write that does not match the expected step aborts. The abort returns the decoder to idle and clears `info_mode` and `bypass_mode`. The next correct sequence is decoded normally.
- R6: If TMO_CYC clock cycles pass without a selected write while a sequence is partly received, the sequence is dropped (the same as R5). A gap shorter than this keeps the sequence alive.
- R7: Unlock followed by A0h arms a program. The next selected write gives PROGRAM (code 3), carrying that write's address and data.
- R8: Unlock, 80h, then a second unlock pair, then 10h gives CHIP_ERASE (code 4). Ending with 30h instead gives SECTOR_ERASE (code 5) at the address of the final write.
- R9: IDENT sets `info_mode`. A full RESET sequence clears it.
- R10: BYPASS sets `bypass_mode`. While it is set, a single A0h write arms a program, and the write after that gives PROGRAM. The writes 90h and then 00h give RESET and clear `bypass_mode`.
- R11: Each suspend and resume sequence gives exactly one strobe with its own code.
- R12: In `status_byte`, bit 7 equals `op_d7` when idle and its complement while `busy` is high. Bit 6 inverts on every selected read while `busy` is high. Bit 5 follows `op_error` and bit 3 follows `erase_window`. Bits 4, 2, 1 and 0 read 0.
- R13: `cmd_valid` never stays high for two cycles in a row. After reset, `cmd_valid`, `info_mode` and `bypass_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 = word (16-bit) bus mode, 0 = byte mode |
| bus_we | input | 1 | Host write strobe, one cycle per bus write |
| bus_re | input | 1 | Host read strobe, one cycle per bus read |
| bus_addr | input | ADDR_W | Host address |
| bus_wdata | input | 16 | Host write data |
| sect_sel | input | NSECT | Main sector selects, active high |
| boot_sel | input | NBOOT | Boot sector selects, active high |
| busy | input | 1 | Embedded program/erase in progress |
| op_d7 | input | 1 | Bit 7 of the data being programmed |
| op_error | input | 1 | Embedded operation error flag |
| erase_window | input | 1 | Sector-erase accept window closed |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 4 | Command code (see R1, R7, R8) |
| cmd_addr | output | ADDR_W | Address of the completing write |
| cmd_data | output | 16 | Data of the completing write |
| info_mode | output | 1 | Identifier / protection read mode active |
| bypass_mode | output | 1 | Unlock bypass active |
| status_byte | output | 8 | Status returned during embedded operations |

## Verification
Complete sequences are run in both bus modes. Junk is placed in the data upper byte and in address bits 12 and above, which shows whether only the intended bits are compared. Broken sequences are also driven: wrong data, a wrong unlock address, an odd word-mode address and a long pause. These separate the abort path from a normal decode, and each one is followed by a good sequence to show the recovery. An unselected write placed in the middle of a valid sequence separates the ignore path from the abort path. Bypass, erase and suspend/resume runs exercise the longer and the shorter command forms.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_NONE         = 4'd0,
    CMD_RESET        = 4'd1,
    CMD_IDENT        = 4'd2,
    CMD_PROGRAM      = 4'd3,
    CMD_CHIP_ERASE   = 4'd4,
    CMD_SECTOR_ERASE = 4'd5,
    CMD_SUSPEND      = 4'd6,
    CMD_RESUME       = 4'd7,
    CMD_BYPASS       = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERS0, S_ERS1, S_ERS2, S_BYX
  } seq_e;

  localparam logic [7:0] OP_RESET  = 8'hF0;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] OP_SECT   = 8'h30;
  localparam logic [7:0] OP_SUSP   = 8'hB0;
  localparam logic [7:0] OP_RESUME = 8'h30;
  localparam logic [7:0] OP_BYPASS = 8'h20;
  localparam logic [7:0] OP_BYEXIT = 8'h00;
  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;

  // Low 12 address bits expected for unlock step 0 or 1 in the given mode.
  function automatic logic [11:0] unlock_addr(input logic wide, input logic second);
    if (wide) return second ? 12'h554 : 12'hAAA;
    else      return second ? 12'hAAA : 12'h555;
  endfunction

  // Word mode admits even addresses only.
  function automatic logic addr_legal(input logic wide, input logic a0);
    return !(wide && a0);
  endfunction

  function automatic logic [7:0] status_pack(input logic busy, input logic d7,
                                             input logic tog, input logic err,
                                             input logic ewin);
    return {busy ? ~d7 : d7, tog, err, 1'b0, ewin, 3'b000};
  endfunction

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
(
  input  logic        wide,
  input  logic [11:0] addr_lo,
  input  logic [7:0]  data_lo,
  output logic        legal,
  output logic        key_a_hit,
  output logic        key_b_hit,
  output logic [7:0]  opcode
);
  assign legal     = addr_legal(wide, addr_lo[0]);
  assign key_a_hit = legal && (addr_lo == unlock_addr(wide, 1'b0)) && (data_lo == KEY_A);
  assign key_b_hit = legal && (addr_lo == unlock_addr(wide, 1'b1)) && (data_lo == KEY_B);
  assign opcode    = data_lo;
endmodule

// File: rtl/flash_cmd_timer.sv
module flash_cmd_timer #(
  parameter int TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expire
);
  localparam int CW = $clog2(TMO_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (kick || !run) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign expire = run && !kick && (cnt == CW'(TMO_CYC - 1));
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       rd_pulse,
  input  logic       op_d7,
  input  logic       op_error,
  input  logic       erase_window,
  output logic [7:0] status_byte
);
  logic tog;

  always_ff @(posedge clk) begin
    if (!rst_n)                tog <= 1'b0;
    else if (rd_pulse && busy) tog <= ~tog;
  end

  assign status_byte = status_pack(busy, op_d7, tog, op_error, erase_window);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int NSECT   = 8,
  parameter int NBOOT   = 4,
  parameter int TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic [NSECT-1:0]  sect_sel,
  input  logic [NBOOT-1:0]  boot_sel,
  input  logic              busy,
  input  logic              op_d7,
  input  logic              op_error,
  input  logic              erase_window,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [15:0]       cmd_data,
  output logic              info_mode,
  output logic              bypass_mode,
  output logic [7:0]        status_byte
);
  seq_e       state, nstate;
  cmd_e       fire_code;
  logic       fire, abort_evt, n_info, n_byp;
  logic       legal, key_a_hit, key_b_hit;
  logic [7:0] opcode;

  // Named internal events, also used by the bound checker.
  logic any_sel, wr_evt, seq_idle, tmo_hit;
  assign any_sel  = |{sect_sel, boot_sel};
  assign wr_evt   = bus_we && any_sel;
  assign seq_idle = (state == S_IDLE);

  flash_cmd_match u_match (
    .wide      (wide_mode),
    .addr_lo   (bus_addr[11:0]),
    .data_lo   (bus_wdata[7:0]),
    .legal     (legal),
    .key_a_hit (key_a_hit),
    .key_b_hit (key_b_hit),
    .opcode    (opcode)
  );

  flash_cmd_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (!seq_idle),
    .kick   (wr_evt),
    .expire (tmo_hit)
  );

  flash_cmd_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .rd_pulse     (bus_re && any_sel),
    .op_d7        (op_d7),
    .op_error     (op_error),
    .erase_window (erase_window),
    .status_byte  (status_byte)
  );

  always_comb begin
    nstate    = state;
    fire      = 1'b0;
    fire_code = CMD_NONE;
    abort_evt = 1'b0;
    n_info    = info_mode;
    n_byp     = bypass_mode;
    if (wr_evt) begin
      if (!legal) begin
        abort_evt = 1'b1;
      end else begin
        case (state)
          S_IDLE: begin
            if (bypass_mode) begin
              if (opcode == OP_PROG)       nstate = S_PROG;
              else if (opcode == OP_IDENT) nstate = S_BYX;
              else                         abort_evt = 1'b1;
            end else if (key_a_hit) nstate = S_UNL1;
            else                    abort_evt = 1'b1;
          end
          S_UNL1: if (key_b_hit) nstate = S_UNL2; else abort_evt = 1'b1;
          S_UNL2: begin
            nstate = S_IDLE;
            case (opcode)
              OP_RESET:  begin fire = 1'b1; fire_code = CMD_RESET;   n_info = 1'b0; end
              OP_IDENT:  begin fire = 1'b1; fire_code = CMD_IDENT;   n_info = 1'b1; end
              OP_BYPASS: begin fire = 1'b1; fire_code = CMD_BYPASS;  n_byp  = 1'b1; end
              OP_SUSP:   begin fire = 1'b1; fire_code = CMD_SUSPEND; end
              OP_RESUME: begin fire = 1'b1; fire_code = CMD_RESUME;  end
              OP_PROG:   nstate = S_PROG;
              OP_ERASE:  nstate = S_ERS0;
              default:   abort_evt = 1'b1;
            endcase
          end
          S_PROG: begin
            nstate = S_IDLE; fire = 1'b1; fire_code = CMD_PROGRAM;
          end
          S_ERS0: if (key_a_hit) nstate = S_ERS1; else abort_evt = 1'b1;
          S_ERS1: if (key_b_hit) nstate = S_ERS2; else abort_evt = 1'b1;
          S_ERS2: begin
            nstate = S_IDLE;
            if (opcode == OP_CHIP)      begin fire = 1'b1; fire_code = CMD_CHIP_ERASE;   end
            else if (opcode == OP_SECT) begin fire = 1'b1; fire_code = CMD_SECTOR_ERASE; end
            else                        abort_evt = 1'b1;
          end
          S_BYX: begin
            nstate = S_IDLE;
            if (opcode == OP_BYEXIT) begin fire = 1'b1; fire_code = CMD_RESET; n_byp = 1'b0; end
            else                     abort_evt = 1'b1;
          end
          default: abort_evt = 1'b1;
        endcase
      end
    end else if (tmo_hit) begin
      abort_evt = 1'b1;
    end
    if (abort_evt) begin
      nstate = S_IDLE;
      n_info = 1'b0;
      n_byp  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      info_mode   <= 1'b0;
      bypass_mode <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_code    <= 4'd0;
      cmd_addr    <= '0;
      cmd_data    <= '0;
    end else begin
      state       <= nstate;
      info_mode   <= n_info;
      bypass_mode <= n_byp;
      cmd_valid   <= fire;
      if (fire) begin
        cmd_code <= fire_code;
        cmd_addr <= bus_addr;
        cmd_data <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wide_mode,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              any_sel,
  input logic              wr_evt,
  input logic              seq_idle,
  input logic              tmo_hit,
  input logic              abort_evt,
  input logic [2:0]        seq_state,
  input logic              busy,
  input logic              op_d7,
  input logic              cmd_valid,
  input logic              info_mode,
  input logic              bypass_mode,
  input logic [7:0]        status_byte
);
  a_r13_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r6_timeout_drops: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (seq_idle && !cmd_valid));

  a_r4_unselected_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !any_sel && !tmo_hit) |=> $stable(seq_state));

  a_r3_odd_word_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wide_mode && bus_addr[0]) |=> (seq_idle && !cmd_valid));

  a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (seq_idle && !info_mode && !bypass_mode));

  a_r12_toggle_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_re && any_sel) |=> (status_byte[6] != $past(status_byte[6])));

  a_r12_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status_byte[7] == !op_d7));
endmodule

bind flash_cmd_decoder flash_cmd_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wide_mode   (wide_mode),
  .bus_we      (bus_we),
  .bus_re      (bus_re),
  .bus_addr    (bus_addr),
  .any_sel     (any_sel),
  .wr_evt      (wr_evt),
  .seq_idle    (seq_idle),
  .tmo_hit     (tmo_hit),
  .abort_evt   (abort_evt),
  .seq_state   (state),
  .busy        (busy),
  .op_d7       (op_d7),
  .cmd_valid   (cmd_valid),
  .info_mode   (info_mode),
  .bypass_mode (bypass_mode),
  .status_byte (status_byte)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wide_mode = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [7:0]    sect_sel = 8'h01;
  logic [3:0]    boot_sel = 4'h0;
  logic          busy = 1'b0, op_d7 = 1'b0, op_error = 1'b0, erase_window = 1'b0;
  logic          cmd_valid, info_mode, bypass_mode;
  logic [3:0]    cmd_code;
  logic [AW-1:0] cmd_addr;
  logic [15:0]   cmd_data;
  logic [7:0]    status_byte;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .NSECT(8), .NBOOT(4), .TMO_CYC(64)) i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sect_sel(sect_sel), .boot_sel(boot_sel),
    .busy(busy), .op_d7(op_d7), .op_error(op_error), .erase_window(erase_window),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .info_mode(info_mode), .bypass_mode(bypass_mode), .status_byte(status_byte)
  );

  typedef struct {
    logic [3:0]    code;
    logic [AW-1:0] addr;
    logic [15:0]   data;
    string         req;
  } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0, n_bad = 0, n_strobe = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [3:0] code, input logic [AW-1:0] a,
                            input logic [15:0] d, input string req);
    exp_t e;
    e.code = code; e.addr = a; e.data = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: every strobe is popped against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      n_strobe++;
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5 unexpected strobe actual=%0h expected=none", cmd_code);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cmd_code == e.code, {e.req, " code"}, 32'(cmd_code), 32'(e.code));
        chk(cmd_addr == e.addr, {e.req, " addr"}, 32'(cmd_addr), 32'(e.addr));
        chk(cmd_data == e.data, {e.req, " data"}, 32'(cmd_data), 32'(e.data));
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic unlock();
    if (wide_mode) begin wr(20'h00AAA, 16'h00AA); wr(20'h00554, 16'h0055); end
    else           begin wr(20'h00555, 16'h00AA); wr(20'h00AAA, 16'h0055); end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++; n_bad++;
      $display("FAIL %s missing strobe actual=none expected=%0h", e.req, e.code);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R13 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk(!cmd_valid, "R13 reset cmd_valid", 32'(cmd_valid), 0);
    chk(!info_mode && !bypass_mode, "R13 reset modes", 32'({info_mode, bypass_mode}), 0);

    // R1 / R4: byte-mode reset with junk in address bits 12 and up
    wr(20'h7F555, 16'h00AA); wr(20'h3CAAA, 16'h0055);
    expect_cmd(4'd1, 20'hF2555, 16'h00F0, "R1 R4 reset");
    wr(20'hF2555, 16'h00F0);
    settle();

    // R9: identifier mode set, then cleared by reset sequence
    unlock(); expect_cmd(4'd2, 20'h00555, 16'h0090, "R9 ident"); wr(20'h00555, 16'h0090);
    settle();
    chk(info_mode, "R9 info set", 32'(info_mode), 1);
    unlock(); expect_cmd(4'd1, 20'h00555, 16'h00F0, "R9 reset"); wr(20'h00555, 16'h00F0);
    settle();
    chk(!info_mode, "R9 info clear", 32'(info_mode), 0);

    // R7 / R3: byte-mode program to an odd address
    unlock(); wr(20'h00555, 16'h00A0);
    expect_cmd(4'd3, 20'h12345, 16'h005A, "R7 R3 program odd byte");
    wr(20'h12345, 16'h005A);
    settle();

    // R2 / R8: word-mode sector erase, junk in upper data byte
    wide_mode = 1'b1;
    wr(20'h00AAA, 16'hC3AA); wr(20'h00554, 16'h7E55); wr(20'h00AAA, 16'h0080);
    unlock();
    expect_cmd(4'd5, 20'h0A000, 16'hFF30, "R2 R8 sector erase");
    wr(20'h0A000, 16'hFF30);
    settle();
    // R8: word-mode chip erase
    unlock(); wr(20'h00AAA, 16'h0080); unlock();
    expect_cmd(4'd4, 20'h00AAA, 16'h0010, "R8 chip erase");
    wr(20'h00AAA, 16'h0010);
    settle();
    // R2: word-mode program carries full 16-bit word
    unlock(); wr(20'h00AAA, 16'h00A0);
    expect_cmd(4'd3, 20'h04002, 16'hBEEF, "R2 R7 word program");
    wr(20'h04002, 16'hBEEF);
    settle();

    // R3: odd address in word mode aborts, then recovery
    base = n_strobe;
    unlock(); wr(20'h00AAB, 16'h00F0);
    settle();
    chk(n_strobe == base, "R3 odd word abort", 32'(n_strobe - base), 0);
    unlock(); expect_cmd(4'd1, 20'h00AAA, 16'h00F0, "R3 recover"); wr(20'h00AAA, 16'h00F0);
    settle();
    wide_mode = 1'b0;

    // R5: wrong data clears identifier mode
    unlock(); expect_cmd(4'd2, 20'h00555, 16'h0090, "R5 ident"); wr(20'h00555, 16'h0090);
    settle();
    base = n_strobe;
    wr(20'h00555, 16'h00AA); wr(20'h00AAA, 16'h0054); wr(20'h00555, 16'h00F0);
    settle();
    chk(!info_mode, "R5 wrong data clears info", 32'(info_mode), 0);
    // R5: wrong unlock address
    wr(20'h00555, 16'h00AA); wr(20'h00555, 16'h0055); wr(20'h00555, 16'h0090);
    settle();
    chk(n_strobe == base && !info_mode, "R5 wrong addr no strobe", 32'(n_strobe - base), 0);

    // R4: unselected write inside a sequence is ignored
    wr(20'h00555, 16'h00AA);
    sect_sel = 8'h00; wr(20'h00000, 16'h0012); sect_sel = 8'h00; boot_sel = 4'h2;
    wr(20'h00AAA, 16'h0055);
    expect_cmd(4'd6, 20'h00555, 16'h00B0, "R4 R11 suspend via boot sel");
    wr(20'h00555, 16'h00B0);
    settle();
    boot_sel = 4'h0; sect_sel = 8'h01;

    // R11: resume
    unlock(); expect_cmd(4'd7, 20'h00555, 16'h0030, "R11 resume"); wr(20'h00555, 16'h0030);
    settle();

    // R6: long gap drops the sequence
    base = n_strobe;
    wr(20'h00555, 16'h00AA);
    repeat (80) @(negedge clk);
    wr(20'h00AAA, 16'h0055); wr(20'h00555, 16'h00F0);
    settle();
    chk(n_strobe == base, "R6 timeout no strobe", 32'(n_strobe - base), 0);
    // R6: shorter gaps keep it alive
    wr(20'h00555, 16'h00AA);
    repeat (40) @(negedge clk);
    wr(20'h00AAA, 16'h0055);
    repeat (40) @(negedge clk);
    expect_cmd(4'd1, 20'h00555, 16'h00F0, "R6 short gap");
    wr(20'h00555, 16'h00F0);
    settle();

    // R10: unlock bypass
    unlock(); expect_cmd(4'd8, 20'h00555, 16'h0020, "R10 bypass"); wr(20'h00555, 16'h0020);
    settle();
    chk(bypass_mode, "R10 bypass set", 32'(bypass_mode), 1);
    wr(20'h00000, 16'h00A0);
    expect_cmd(4'd3, 20'h00301, 16'h00C3, "R10 bypass program");
    wr(20'h00301, 16'h00C3);
    settle();
    wr(20'h00000, 16'h0090);
    expect_cmd(4'd1, 20'h00000, 16'h0000, "R10 bypass exit");
    wr(20'h00000, 16'h0000);
    settle();
    chk(!bypass_mode, "R10 bypass clear", 32'(bypass_mode), 0);

    // R12: status byte
    op_d7 = 1'b1; op_error = 1'b1; erase_window = 1'b1; busy = 1'b0;
    @(negedge clk);
    chk(status_byte == 8'hA8, "R12 idle status", 32'(status_byte), 32'h A8);
    busy = 1'b1;
    @(negedge clk);
    chk(status_byte == 8'h28, "R12 busy poll", 32'(status_byte), 32'h28);
    rd();
    chk(status_byte == 8'h68, "R12 toggle 1", 32'(status_byte), 32'h68);
    rd();
    chk(status_byte == 8'h28, "R12 toggle 2", 32'(status_byte), 32'h28);
    busy = 1'b0; op_error = 1'b0; erase_window = 1'b0; op_d7 = 1'b0;
    rd();
    chk(status_byte == 8'h00, "R12 no toggle idle", 32'(status_byte), 0);

    settle();
    finish_run();
  end
endmodule